// File: doc/BRIEF.md
# Packed Lane Shift-Left Unit

This block shifts a 64-bit packed operand to the left, lane by lane. A mode input picks one of two lane layouts: four 16-bit lanes or two 32-bit lanes. Every lane moves by the same unsigned count. That count comes from one of two places: the full 64-bit value of a second register operand, or a 5-bit immediate. Bits never pass from one lane into the next, and the low-order positions that a shift vacates fill with zeros.

The count is clamped to the lane width. Any count at or beyond the lane width clears every lane, and this includes a register count with a high bit set. Register data carries a one-bit poison tag. The result's tag is the OR of the data operand's tag and the count operand's tag, and an immediate count adds no poison.

The result, tag and destination index are captured in one output register stage. The unit sends them out with a one-cycle write-enable pulse. A write happens only when the request is valid and its qualifying predicate is true. Otherwise the held outputs do not change.

Top module: `lane_shl_unit`

## Requirements
- R1: With `in_mode_wide`=0, the operand is four 16-bit lanes (bits 15:0, 31:16, 47:32, 63:48). Each lane shifts left on its own, no bit crosses into a neighbouring lane, and vacated low bits are zero.
- R2: With `in_mode_wide`=1, the operand is two 32-bit lanes (bits 31:0, 63:32), shifted as in R1.
- R3: With `in_use_imm`=1, the count is the 5-bit `in_imm` read as unsigned, and a count of 0 returns the data unchanged. With `in_use_imm`=0, the count is all 64 bits of `in_cnt_reg` read as unsigned.
- R4: In 16-bit lane mode, any count of 16 or more gives a result of all zeros.
- R5: In 32-bit lane mode, any count of 32 or more gives a result of all zeros.
- R6: Any nonzero bit above bit 5 of the register count forces an all-zero result, whatever the low bits hold (for example, bit 40 set with a low value of 3).
- R7: `out_tag` equals `in_data_tag` OR `in_cnt_tag` in the register-count form, and equals `in_data_tag` alone in the immediate form.
- R8: `out_we` is high in the cycle after a rising clock edge exactly when `in_valid` AND `in_pred` were high at that edge. `out_result`, `out_tag` and `out_dest` are loaded on that same edge.
- R9: When no write is enabled (predicate false or request not valid), `out_result`, `out_tag` and `out_dest` keep their previous values.
- R10: While reset is asserted, `out_we`, `out_result`, `out_tag` and `out_dest` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present this cycle |
| in_pred | input | 1 | Qualifying predicate; a false value suppresses the write |
| in_mode_wide | input | 1 | 0: four 16-bit lanes, 1: two 32-bit lanes |
| in_use_imm | input | 1 | 1: count from `in_imm`, 0: count from `in_cnt_reg` |
| in_data | input | 64 | Packed operand to shift |
| in_data_tag | input | 1 | Poison tag of the data operand |
| in_cnt_reg | input | 64 | Register count operand, unsigned |
| in_cnt_tag | input | 1 | Poison tag of the register count |
| in_imm | input | 5 | Immediate count, unsigned |
| in_dest | input | 7 | Destination register index |
| out_we | output | 1 | One-cycle write enable |
| out_result | output | 64 | Shifted result |
| out_tag | output | 1 | Poison tag of the result |
| out_dest | output | 7 | Destination index for the write |

## Verification
Each result, tag, destination index and write pulse is due exactly one rising edge after the request is presented. The bench drives each request on a falling edge and reads the outputs on the following falling edge, half a period after the capturing edge. The driver queues the expected item for every request whose valid and predicate are both true. The monitor pops that item on the first falling edge where `out_we` is high. On every falling edge where `out_we` is low, the monitor checks that the last written values are still held.

// File: rtl/lane_shl_pkg.sv
package lane_shl_pkg;

   typedef enum logic {
      LANES_NARROW = 1'b0,
      LANES_WIDE   = 1'b1
   } lane_mode_e;

   function automatic int unsigned cnt_width(input int unsigned max_lane_w);
      return $clog2(max_lane_w) + 1;
   endfunction

endpackage

// File: rtl/lane_shl_cnt_sel.sv
module lane_shl_cnt_sel
   import lane_shl_pkg::*;
#(
   parameter int unsigned DATA_W   = 64,
   parameter int unsigned IMM_W    = 5,
   parameter int unsigned NARROW_W = 16,
   parameter int unsigned WIDE_W   = 32,
   parameter int unsigned CNT_W    = 6
) (
   input  lane_mode_e          mode,
   input  logic                use_imm,
   input  logic [DATA_W-1:0]   cnt_reg,
   input  logic                cnt_tag,
   input  logic [IMM_W-1:0]    imm,
   output logic [CNT_W-1:0]    cnt_clamped,
   output logic                cnt_tag_eff
);

   localparam logic [DATA_W-1:0] LIM_NARROW = DATA_W'(NARROW_W);
   localparam logic [DATA_W-1:0] LIM_WIDE   = DATA_W'(WIDE_W);

   if (IMM_W >= DATA_W) begin : g_bad_imm
      $error("lane_shl_cnt_sel: IMM_W must be narrower than DATA_W");
   end
   if ((1 << (CNT_W - 1)) < WIDE_W) begin : g_bad_cnt
      $error("lane_shl_cnt_sel: CNT_W cannot hold the wide lane width");
   end

   logic [DATA_W-1:0] raw_cnt;
   logic [DATA_W-1:0] lim_sel;
   logic              over_lim;

   always_comb begin
      if (use_imm) begin
         raw_cnt = {{(DATA_W-IMM_W){1'b0}}, imm};
      end else begin
         raw_cnt = cnt_reg;
      end
   end

   always_comb begin
      lim_sel = (mode == LANES_WIDE) ? LIM_WIDE : LIM_NARROW;
   end

   // Full-width unsigned compare: high count bits are never discarded.
   assign over_lim = (raw_cnt > lim_sel);

   always_comb begin
      if (over_lim) begin
         cnt_clamped = lim_sel[CNT_W-1:0];
      end else begin
         cnt_clamped = raw_cnt[CNT_W-1:0];
      end
   end

   assign cnt_tag_eff = cnt_tag & ~use_imm;

endmodule

// File: rtl/lane_shl_lane.sv
module lane_shl_lane #(
   parameter int unsigned LANE_W     = 16,
   parameter int unsigned CNT_W      = 6,
   parameter bit          LOG_STAGES = 1'b1
) (
   input  logic [LANE_W-1:0] lane_in,
   input  logic [CNT_W-1:0]  cnt,
   output logic [LANE_W-1:0] lane_out
);

   localparam int unsigned SH_W = $clog2(LANE_W);

   if ((1 << SH_W) != LANE_W) begin : g_bad_lane
      $error("lane_shl_lane: LANE_W must be a power of two");
   end
   if (CNT_W <= SH_W) begin : g_bad_cntw
      $error("lane_shl_lane: CNT_W must exceed log2(LANE_W)");
   end

   if (LOG_STAGES) begin : g_log
      logic [LANE_W-1:0] stage [0:SH_W];
      logic              clear_all;

      assign stage[0]  = lane_in;
      assign clear_all = |cnt[CNT_W-1:SH_W];

      for (genvar s = 0; s < SH_W; s++) begin : g_stage
         assign stage[s+1] = cnt[s] ? (stage[s] << (1 << s)) : stage[s];
      end

      assign lane_out = clear_all ? '0 : stage[SH_W];
   end else begin : g_flat
      always_comb begin
         if (int'(cnt) >= int'(LANE_W)) begin
            lane_out = '0;
         end else begin
            lane_out = lane_in << cnt;
         end
      end
   end

endmodule

// File: rtl/lane_shl_array.sv
module lane_shl_array #(
   parameter int unsigned DATA_W     = 64,
   parameter int unsigned LANE_W     = 16,
   parameter int unsigned CNT_W      = 6,
   parameter bit          LOG_STAGES = 1'b1
) (
   input  logic [DATA_W-1:0] data_in,
   input  logic [CNT_W-1:0]  cnt,
   output logic [DATA_W-1:0] data_out
);

   localparam int unsigned N_LANES = DATA_W / LANE_W;

   if (N_LANES * LANE_W != DATA_W) begin : g_bad_split
      $error("lane_shl_array: DATA_W must be a multiple of LANE_W");
   end

   for (genvar g = 0; g < N_LANES; g++) begin : g_lane
      lane_shl_lane #(
         .LANE_W     (LANE_W),
         .CNT_W      (CNT_W),
         .LOG_STAGES (LOG_STAGES)
      ) u_lane (
         .lane_in  (data_in [g*LANE_W +: LANE_W]),
         .cnt      (cnt),
         .lane_out (data_out[g*LANE_W +: LANE_W])
      );
   end

endmodule

// File: rtl/lane_shl_unit.sv
module lane_shl_unit
   import lane_shl_pkg::*;
#(
   parameter int unsigned DATA_W     = 64,
   parameter int unsigned NARROW_W   = 16,
   parameter int unsigned WIDE_W     = 32,
   parameter int unsigned IMM_W      = 5,
   parameter int unsigned DEST_W     = 7,
   parameter bit          LOG_STAGES = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_pred,
   input  logic              in_mode_wide,
   input  logic              in_use_imm,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_data_tag,
   input  logic [DATA_W-1:0] in_cnt_reg,
   input  logic              in_cnt_tag,
   input  logic [IMM_W-1:0]  in_imm,
   input  logic [DEST_W-1:0] in_dest,
   output logic              out_we,
   output logic [DATA_W-1:0] out_result,
   output logic              out_tag,
   output logic [DEST_W-1:0] out_dest
);

   localparam int unsigned CNT_W = cnt_width(WIDE_W);

   if (NARROW_W >= WIDE_W) begin : g_bad_order
      $error("lane_shl_unit: NARROW_W must be smaller than WIDE_W");
   end
   if (WIDE_W > DATA_W) begin : g_bad_wide
      $error("lane_shl_unit: WIDE_W must not exceed DATA_W");
   end

   lane_mode_e        mode;
   logic [CNT_W-1:0]  cnt_clamped;
   logic              cnt_tag_eff;
   logic [DATA_W-1:0] res_narrow;
   logic [DATA_W-1:0] res_wide;
   logic [DATA_W-1:0] res_sel;
   logic              write_en;

   assign mode = lane_mode_e'(in_mode_wide);

   lane_shl_cnt_sel #(
      .DATA_W   (DATA_W),
      .IMM_W    (IMM_W),
      .NARROW_W (NARROW_W),
      .WIDE_W   (WIDE_W),
      .CNT_W    (CNT_W)
   ) u_cnt (
      .mode        (mode),
      .use_imm     (in_use_imm),
      .cnt_reg     (in_cnt_reg),
      .cnt_tag     (in_cnt_tag),
      .imm         (in_imm),
      .cnt_clamped (cnt_clamped),
      .cnt_tag_eff (cnt_tag_eff)
   );

   lane_shl_array #(
      .DATA_W     (DATA_W),
      .LANE_W     (NARROW_W),
      .CNT_W      (CNT_W),
      .LOG_STAGES (LOG_STAGES)
   ) u_narrow (
      .data_in  (in_data),
      .cnt      (cnt_clamped),
      .data_out (res_narrow)
   );

   lane_shl_array #(
      .DATA_W     (DATA_W),
      .LANE_W     (WIDE_W),
      .CNT_W      (CNT_W),
      .LOG_STAGES (LOG_STAGES)
   ) u_wide (
      .data_in  (in_data),
      .cnt      (cnt_clamped),
      .data_out (res_wide)
   );

   assign res_sel  = (mode == LANES_WIDE) ? res_wide : res_narrow;
   assign write_en = in_valid & in_pred;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_we <= 1'b0;
      end else begin
         out_we <= write_en;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_result <= '0;
         out_tag    <= 1'b0;
         out_dest   <= '0;
      end else if (write_en) begin
         out_result <= res_sel;
         out_tag    <= in_data_tag | cnt_tag_eff;
         out_dest   <= in_dest;
      end
   end

endmodule

// File: rtl/lane_shl_unit_chk.sv
module lane_shl_unit_chk #(
   parameter int unsigned DATA_W   = 64,
   parameter int unsigned NARROW_W = 16,
   parameter int unsigned WIDE_W   = 32,
   parameter int unsigned IMM_W    = 5,
   parameter int unsigned DEST_W   = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_pred,
   input logic              in_mode_wide,
   input logic              in_use_imm,
   input logic [DATA_W-1:0] in_data,
   input logic              in_data_tag,
   input logic [DATA_W-1:0] in_cnt_reg,
   input logic              in_cnt_tag,
   input logic [IMM_W-1:0]  in_imm,
   input logic [DEST_W-1:0] in_dest,
   input logic              out_we,
   input logic [DATA_W-1:0] out_result,
   input logic              out_tag,
   input logic [DEST_W-1:0] out_dest
);

   localparam int unsigned HI_LO = $clog2(WIDE_W) + 1;

   always @(posedge clk) begin
      if (!rst_n) begin
         a_r10_reset_state: assert (!out_we && out_result == '0 && !out_tag && out_dest == '0);
      end
   end

   a_r8_we_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (out_we == $past(in_valid && in_pred)));

   a_r8_dest_latched: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && out_we) |-> (out_dest == $past(in_dest)));

   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !out_we) |-> ($stable(out_result) && $stable(out_tag) && $stable(out_dest)));

   a_r7_tag_merge: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && out_we) |->
         (out_tag == $past(in_data_tag || (!in_use_imm && in_cnt_tag))));

   a_r3_imm_zero_identity: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && out_we && $past(in_use_imm && in_imm == '0)) |->
         (out_result == $past(in_data)));

   a_r4_narrow_clear: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && out_we &&
       $past(!in_mode_wide && in_use_imm && int'(in_imm) >= int'(NARROW_W))) |->
         (out_result == '0));

   a_r6_high_bits_clear: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && out_we && $past(!in_use_imm && (|in_cnt_reg[DATA_W-1:HI_LO]))) |->
         (out_result == '0));

endmodule

bind lane_shl_unit lane_shl_unit_chk #(
   .DATA_W   (DATA_W),
   .NARROW_W (NARROW_W),
   .WIDE_W   (WIDE_W),
   .IMM_W    (IMM_W),
   .DEST_W   (DEST_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .in_valid     (in_valid),
   .in_pred      (in_pred),
   .in_mode_wide (in_mode_wide),
   .in_use_imm   (in_use_imm),
   .in_data      (in_data),
   .in_data_tag  (in_data_tag),
   .in_cnt_reg   (in_cnt_reg),
   .in_cnt_tag   (in_cnt_tag),
   .in_imm       (in_imm),
   .in_dest      (in_dest),
   .out_we       (out_we),
   .out_result   (out_result),
   .out_tag      (out_tag),
   .out_dest     (out_dest)
);

// File: tb/lane_shl_unit_tb.sv
module lane_shl_unit_tb;

   localparam int CLK_PERIOD = 10;

   typedef struct {
      logic [63:0] result;
      logic        tag;
      logic [6:0]  dest;
      string       req;
   } exp_item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_pred = 1'b0;
   logic        in_mode_wide = 1'b0;
   logic        in_use_imm = 1'b0;
   logic [63:0] in_data = '0;
   logic        in_data_tag = 1'b0;
   logic [63:0] in_cnt_reg = '0;
   logic        in_cnt_tag = 1'b0;
   logic [4:0]  in_imm = '0;
   logic [6:0]  in_dest = '0;
   logic        out_we;
   logic [63:0] out_result;
   logic        out_tag;
   logic [6:0]  out_dest;

   int          n_checks = 0;
   int          n_errors = 0;
   bit          mon_en = 1'b0;
   bit          have_last = 1'b0;
   bit          finished = 1'b0;
   logic [63:0] last_result;
   logic        last_tag;
   logic [6:0]  last_dest;
   exp_item_t   sb_q [$];

   always #(CLK_PERIOD/2) clk = ~clk;

   lane_shl_unit u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .in_valid     (in_valid),
      .in_pred      (in_pred),
      .in_mode_wide (in_mode_wide),
      .in_use_imm   (in_use_imm),
      .in_data      (in_data),
      .in_data_tag  (in_data_tag),
      .in_cnt_reg   (in_cnt_reg),
      .in_cnt_tag   (in_cnt_tag),
      .in_imm       (in_imm),
      .in_dest      (in_dest),
      .out_we       (out_we),
      .out_result   (out_result),
      .out_tag      (out_tag),
      .out_dest     (out_dest)
   );

   function automatic logic [63:0] model_shift(input bit wide, input logic [63:0] data,
                                               input logic [63:0] cnt);
      int          lw;
      logic [63:0] res;
      logic [31:0] lane;
      lw  = wide ? 32 : 16;
      res = '0;
      for (int l = 0; l < 64 / lw; l++) begin
         lane = '0;
         for (int b = 0; b < lw; b++) lane[b] = data[l*lw + b];
         if (cnt >= 64'(lw)) lane = '0;
         else lane = lane << cnt[5:0];
         for (int b = 0; b < lw; b++) res[l*lw + b] = lane[b];
      end
      return res;
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic drive(input bit wide, input bit imm_form, input logic [63:0] data,
                        input bit dtag, input logic [63:0] cnt, input bit ctag,
                        input logic [4:0] imm, input bit valid, input bit pred,
                        input logic [6:0] dest, input string req);
      exp_item_t it;
      logic [63:0] eff;
      @(negedge clk);
      in_valid     = valid;
      in_pred      = pred;
      in_mode_wide = wide;
      in_use_imm   = imm_form;
      in_data      = data;
      in_data_tag  = dtag;
      in_cnt_reg   = cnt;
      in_cnt_tag   = ctag;
      in_imm       = imm;
      in_dest      = dest;
      if (valid && pred) begin
         eff       = imm_form ? {59'd0, imm} : cnt;
         it.result = model_shift(wide, data, eff);
         it.tag    = dtag | (ctag & ~imm_form);
         it.dest   = dest;
         it.req    = req;
         sb_q.push_back(it);
      end
   endtask

   task automatic idle();
      @(negedge clk);
      in_valid = 1'b0;
      in_pred  = 1'b0;
   endtask

   // Monitor: results are due one rising edge after drive, sampled at the next falling edge.
   always @(negedge clk) begin
      if (mon_en) begin
         if (out_we) begin
            if (sb_q.size() == 0) begin
               check("R8 unexpected write", {63'd0, out_we}, 64'd0);
            end else begin
               exp_item_t it;
               it = sb_q.pop_front();
               check(it.req, out_result, it.result);
               check("R7 tag", {63'd0, out_tag}, {63'd0, it.tag});
               check("R8 dest", {57'd0, out_dest}, {57'd0, it.dest});
            end
            last_result = out_result;
            last_tag    = out_tag;
            last_dest   = out_dest;
            have_last   = 1'b1;
         end else if (have_last) begin
            check("R9 hold result", out_result, last_result);
            check("R9 hold tag/dest", {56'd0, out_tag, out_dest}, {56'd0, last_tag, last_dest});
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_errors++;
         n_checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      logic [63:0] cnts [8];
      logic [63:0] pat_a, pat_b;
      cnts[0] = 64'd0;  cnts[1] = 64'd15; cnts[2] = 64'd16; cnts[3] = 64'd17;
      cnts[4] = 64'd31; cnts[5] = 64'd32; cnts[6] = 64'd33; cnts[7] = '1;
      pat_a = 64'hF00F_8421_FFFF_0001;
      pat_b = 64'h8000_7FFF_1234_C3A5;

      repeat (3) @(negedge clk);
      // R10: outputs during reset
      check("R10 reset we", {63'd0, out_we}, 64'd0);
      check("R10 reset result", out_result, 64'd0);
      check("R10 reset tag/dest", {56'd0, out_tag, out_dest}, 64'd0);
      @(negedge clk);
      rst_n  = 1'b1;
      mon_en = 1'b1;

      // R1 / R4: narrow lanes, register counts including clamp corners
      for (int i = 0; i < 8; i++) begin
         drive(1'b0, 1'b0, pat_a, 1'b0, cnts[i], 1'b0, 5'd0, 1'b1, 1'b1, 7'(i), "R1/R4 narrow reg");
         drive(1'b0, 1'b0, pat_b, 1'b0, cnts[i], 1'b0, 5'd0, 1'b1, 1'b1, 7'(i+8), "R1/R4 narrow reg");
      end
      // R2 / R5: wide lanes, register counts
      for (int i = 0; i < 8; i++) begin
         drive(1'b1, 1'b0, pat_a, 1'b0, cnts[i], 1'b0, 5'd0, 1'b1, 1'b1, 7'(i+16), "R2/R5 wide reg");
         drive(1'b1, 1'b0, pat_b, 1'b0, cnts[i], 1'b0, 5'd0, 1'b1, 1'b1, 7'(i+24), "R2/R5 wide reg");
      end
      // R3: immediate form, both modes, all 32 values; register count set to garbage
      for (int k = 0; k < 32; k++) begin
         drive(1'b0, 1'b1, pat_b, 1'b0, 64'hFFFF_0000_0000_0001, 1'b1, 5'(k), 1'b1, 1'b1,
               7'(k), "R3 imm narrow");
         drive(1'b1, 1'b1, pat_a, 1'b0, 64'd3, 1'b1, 5'(k), 1'b1, 1'b1, 7'(k+32), "R3 imm wide");
      end
      // R6: high count bit with small low value
      drive(1'b0, 1'b0, pat_a, 1'b0, (64'd1 << 40) | 64'd3, 1'b0, 5'd0, 1'b1, 1'b1, 7'd90, "R6 bit40 narrow");
      drive(1'b1, 1'b0, pat_b, 1'b0, (64'd1 << 40) | 64'd3, 1'b0, 5'd0, 1'b1, 1'b1, 7'd91, "R6 bit40 wide");
      drive(1'b1, 1'b0, pat_b, 1'b0, (64'd1 << 6) | 64'd1, 1'b0, 5'd0, 1'b1, 1'b1, 7'd92, "R6 bit6 wide");
      drive(1'b0, 1'b0, pat_b, 1'b0, 64'd1, 1'b0, 5'd0, 1'b1, 1'b1, 7'd93, "R1 single shift");
      // R7: tag combinations in both count forms
      for (int t = 0; t < 4; t++) begin
         drive(1'b0, 1'b0, pat_a, t[0], 64'd2, t[1], 5'd0, 1'b1, 1'b1, 7'(100+t), "R7 tag reg form");
         drive(1'b1, 1'b1, pat_a, t[0], 64'd2, t[1], 5'd4, 1'b1, 1'b1, 7'(110+t), "R7 tag imm form");
      end
      // R9: predicate false and not-valid requests must not write
      drive(1'b0, 1'b0, pat_b, 1'b0, 64'd4, 1'b0, 5'd0, 1'b1, 1'b1, 7'd5, "R8 before hold");
      drive(1'b1, 1'b0, ~pat_b, 1'b1, 64'd1, 1'b1, 5'd0, 1'b1, 1'b0, 7'd77, "R9 pred false");
      drive(1'b0, 1'b1, pat_a, 1'b1, 64'd0, 1'b0, 5'd2, 1'b0, 1'b1, 7'd78, "R9 not valid");
      drive(1'b0, 1'b0, pat_a, 1'b1, '1, 1'b1, 5'd0, 1'b1, 1'b0, 7'd79, "R9 pred false");
      drive(1'b1, 1'b0, pat_a, 1'b0, 64'd8, 1'b0, 5'd0, 1'b1, 1'b1, 7'd6, "R8 after hold");
      for (int c = 0; c < 8; c++) begin
         drive(1'b0, 1'b0, pat_a, 1'b0, cnts[c], 1'b1, 5'd0, 1'b1, 1'b0, 7'd99, "R9 pred false sweep");
      end
      idle();
      idle();
      idle();
      check("R8 all writes seen", 64'(sb_q.size()), 64'd0);
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule